// File: doc/BRIEF.md
# Lane Drive Level Adjust Calculator

This block sits in a serial display link transmitter. During link training the receiving sink reports, for each lane, the voltage swing and pre-emphasis it wants next. The transmitter drives every lane with one common setting, so those per-lane requests have to be merged into a single drive byte.

The merge follows fixed rules. The block first finds the strongest request across the lanes that are in use. It then clamps the pre-emphasis to what the source supports and caps the swing according to the pre-emphasis chosen. Finally it clamps the swing to the source's own limit. Whenever a source limit is what set a value, a "maximum reached" flag is raised in the byte.

A one-cycle `start` pulse captures the inputs. The resulting drive byte is registered and copied to all four lane outputs, and `done` pulses in the cycle after `start`. Between starts the outputs hold their values. A configuration error output flags source limits that are not allowed.

Top module: `lane_drive_adjust`

## Requirements
- R1: The swing and pre-emphasis used are the largest requested across lanes 0 to lane_cnt-1. Request nibbles of lanes at or above lane_cnt have no effect. Lane i's request is adj_req[4i+3:4i], with swing in bits [1:0] and pre-emphasis in bits [3:2] of the nibble. lane_cnt takes 1, 2 or 4.
- R2: When the largest pre-emphasis is at or above src_emph_max, the pre-emphasis becomes src_emph_max and the pre-emphasis-max flag is set; otherwise that flag is clear.
- R3: The swing is capped by the pre-emphasis in use. Pre-emphasis 0 allows swing up to 3, 1 allows up to 2, 2 allows up to 1, and 3 allows only 0.
- R4: After the R3 cap, a swing at or above src_swing_max becomes src_swing_max and sets the swing-max flag; otherwise that flag is clear.
- R5: cfg_err, captured with each start, is 1 when src_emph_max or src_swing_max is below level 2, and 0 otherwise.
- R6: All four lane bytes of lane_drive carry the same drive byte, whatever lane_cnt is.
- R7: The drive byte layout is swing in [1:0], swing-max flag in [2], pre-emphasis in [4:3], pre-emphasis-max flag in [5], and 0 in [7:6]. Lane n occupies lane_drive[8n+7:8n].
- R8: done is 1 in exactly the cycle after a start pulse. Without start, lane_drive and cfg_err keep their values, even when the other inputs change.
- R9: A synchronous active-high reset clears lane_drive, done and cfg_err to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to compute a new drive byte |
| lane_cnt | input | 3 | Number of active lanes (1, 2 or 4) |
| adj_req | input | 16 | Per-lane adjust requests, one nibble per lane |
| src_swing_max | input | 2 | Highest swing level the source supports |
| src_emph_max | input | 2 | Highest pre-emphasis level the source supports |
| lane_drive | output | 32 | Registered drive byte for each of four lanes |
| done | output | 1 | Pulses the cycle after start |
| cfg_err | output | 1 | Source limits outside the allowed levels |

## Verification
The merge is tried with three kinds of request pattern. In the first, strong requests sit only in inactive lanes. In the second, the strongest request is in the highest lane. The third uses a single active lane. Together these show whether the lane mask and the maximum search are correct. A further set of requests places the values on each side of both source limits and of the pre-emphasis-dependent swing ceiling. Each of these results can only be produced by the right clamp order and the right flag. Changing the inputs without a start, and using illegal source limits, shows that the outputs hold between starts and that cfg_err is decoded correctly.

// File: rtl/drvadj_pkg.sv
package drvadj_pkg;

    localparam int LVL_W = 2;
    localparam int NIB_W = 2 * LVL_W;

    typedef logic [LVL_W-1:0] lvl_t;

    // Drive byte: [7:6] zero, [5] emph limit hit, [4:3] emph, [2] swing limit hit, [1:0] swing
    typedef struct packed {
        logic [1:0] rsvd;
        logic       emph_hit;
        lvl_t       emph;
        logic       swing_hit;
        lvl_t       swing;
    } drive_t;

    // Highest swing allowed for a given pre-emphasis level
    function automatic lvl_t swing_ceiling(lvl_t emph);
        return lvl_t'(2'd3 - emph);
    endfunction

    // A source limit is legal only at level 2 or 3
    function automatic logic limit_legal(lvl_t lim);
        return lim[1];
    endfunction

endpackage

// File: rtl/drvadj_lane_max.sv
module drvadj_lane_max
    import drvadj_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic [NUM_LANES*NIB_W-1:0]       req,
    input  logic [$clog2(NUM_LANES+1)-1:0]   lane_cnt,
    output lvl_t                             swing_max,
    output lvl_t                             emph_max
);
    localparam int CNT_W = $clog2(NUM_LANES + 1);

    logic [NUM_LANES:0][LVL_W-1:0] swing_chain;
    logic [NUM_LANES:0][LVL_W-1:0] emph_chain;

    assign swing_chain[0] = '0;
    assign emph_chain[0]  = '0;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic active;
        lvl_t swing_i;
        lvl_t emph_i;

        assign active  = (CNT_W'(i) < lane_cnt);
        assign swing_i = active ? req[i*NIB_W +: LVL_W]         : '0;
        assign emph_i  = active ? req[i*NIB_W + LVL_W +: LVL_W] : '0;

        assign swing_chain[i+1] = (swing_i > swing_chain[i]) ? swing_i : swing_chain[i];
        assign emph_chain[i+1]  = (emph_i  > emph_chain[i])  ? emph_i  : emph_chain[i];
    end

    assign swing_max = swing_chain[NUM_LANES];
    assign emph_max  = emph_chain[NUM_LANES];

endmodule

// File: rtl/drvadj_limit.sv
module drvadj_limit
    import drvadj_pkg::*;
(
    input  lvl_t   swing_req,
    input  lvl_t   emph_req,
    input  lvl_t   src_swing_max,
    input  lvl_t   src_emph_max,
    output drive_t drive,
    output logic   cfg_bad
);
    lvl_t emph_d;
    logic emph_hit_d;
    lvl_t ceil_d;
    lvl_t swing_capped;
    lvl_t swing_d;
    logic swing_hit_d;

    // Stage 1: clamp pre-emphasis to the source limit
    always_comb begin
        emph_d     = emph_req;
        emph_hit_d = 1'b0;
        if (emph_req >= src_emph_max) begin
            emph_d     = src_emph_max;
            emph_hit_d = 1'b1;
        end
    end

    // Stage 2: swing ceiling follows the pre-emphasis in use
    always_comb begin
        ceil_d       = swing_ceiling(emph_d);
        swing_capped = (swing_req > ceil_d) ? ceil_d : swing_req;
    end

    // Stage 3: clamp swing to the source limit
    always_comb begin
        swing_d     = swing_capped;
        swing_hit_d = 1'b0;
        if (swing_capped >= src_swing_max) begin
            swing_d     = src_swing_max;
            swing_hit_d = 1'b1;
        end
    end

    always_comb begin
        drive           = '0;
        drive.swing     = swing_d;
        drive.swing_hit = swing_hit_d;
        drive.emph      = emph_d;
        drive.emph_hit  = emph_hit_d;
    end

    assign cfg_bad = !limit_legal(src_emph_max) || !limit_legal(src_swing_max);

endmodule

// File: rtl/lane_drive_adjust.sv
module lane_drive_adjust
    import drvadj_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start,
    input  logic [$clog2(NUM_LANES+1)-1:0]     lane_cnt,
    input  logic [NUM_LANES*NIB_W-1:0]         adj_req,
    input  logic [LVL_W-1:0]                   src_swing_max,
    input  logic [LVL_W-1:0]                   src_emph_max,
    output logic [NUM_LANES*8-1:0]             lane_drive,
    output logic                               done,
    output logic                               cfg_err
);
    typedef struct packed {
        logic [NUM_LANES-1:0][7:0] drive;
        logic                      done;
        logic                      cfg_err;
    } state_t;

    state_t st_d, st_q;

    lvl_t   req_swing;
    lvl_t   req_emph;
    drive_t drv_byte;
    logic   cfg_bad;

    drvadj_lane_max #(
        .NUM_LANES (NUM_LANES)
    ) u_lane_max (
        .req       (adj_req),
        .lane_cnt  (lane_cnt),
        .swing_max (req_swing),
        .emph_max  (req_emph)
    );

    drvadj_limit u_limit (
        .swing_req     (req_swing),
        .emph_req      (req_emph),
        .src_swing_max (src_swing_max),
        .src_emph_max  (src_emph_max),
        .drive         (drv_byte),
        .cfg_bad       (cfg_bad)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            for (int i = 0; i < NUM_LANES; i++) begin
                st_d.drive[i] = drv_byte;
            end
            st_d.done    = 1'b1;
            st_d.cfg_err = cfg_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lane_drive = st_q.drive;
    assign done       = st_q.done;
    assign cfg_err    = st_q.cfg_err;

    drive_t lane0_q;
    assign lane0_q = drive_t'(st_q.drive[0]);

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> done); // R8
    AST_DONE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done); // R8
    AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(lane_drive) && $stable(cfg_err)); // R8
    AST_SWING_CEILING: assert property (@(posedge clk) disable iff (rst)
        done |-> ({1'b0, lane0_q.swing} + {1'b0, lane0_q.emph}) <= 3'd3); // R3
    AST_EMPH_FLAG_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (done && lane0_q.emph_hit) |-> lane0_q.emph == $past(src_emph_max)); // R2
    AST_SWING_FLAG_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (done && lane0_q.swing_hit) |-> lane0_q.swing == $past(src_swing_max)); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        done |-> lane0_q.rsvd == 2'b00); // R7

endmodule

// File: tb/lane_drive_adjust_tb.sv
module lane_drive_adjust_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  lane_cnt;
    logic [15:0] adj_req;
    logic [1:0]  src_swing_max;
    logic [1:0]  src_emph_max;
    logic [31:0] lane_drive;
    logic        done;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lane_drive_adjust u_dut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .lane_cnt      (lane_cnt),
        .adj_req       (adj_req),
        .src_swing_max (src_swing_max),
        .src_emph_max  (src_emph_max),
        .lane_drive    (lane_drive),
        .done          (done),
        .cfg_err       (cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Checks every lane byte against one expected value (R6)
    task automatic check_lanes(input string req, input logic [7:0] exp);
        for (int i = 0; i < 4; i++) begin
            check(lane_drive[i*8 +: 8] == exp, req, lane_drive[i*8 +: 8], exp);
        end
    endtask

    // Pulse start with given inputs; returns at the negedge where done should be high
    task automatic run(input logic [2:0] cnt, input logic [15:0] req,
                       input logic [1:0] sw_max, input logic [1:0] pe_max);
        @(negedge clk);
        lane_cnt      = cnt;
        adj_req       = req;
        src_swing_max = sw_max;
        src_emph_max  = pe_max;
        start         = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; lane_cnt = 3'd4; adj_req = '0;
        src_swing_max = 2'd3; src_emph_max = 2'd3;
        repeat (3) @(negedge clk);
        check(lane_drive == 32'h0, "R9 drive", lane_drive, 0);
        check(done == 1'b0, "R9 done", done, 0);
        check(cfg_err == 1'b0, "R9 cfg_err", cfg_err, 0);
        rst = 1'b0;
    endtask

    task automatic t_lane_mask();
        run(3'd2, 16'hFF61, 2'd3, 2'd3);
        check(done == 1'b1, "R8 done after start", done, 1);
        check_lanes("R1 inactive lanes ignored", 8'h0A);
        run(3'd1, 16'hFFF1, 2'd3, 2'd3);
        check_lanes("R1 single lane R6", 8'h01);
        run(3'd4, 16'h6000, 2'd3, 2'd3);
        check_lanes("R1 top lane counted", 8'h0A);
    endtask

    task automatic t_emph_limit();
        run(3'd4, 16'h0C00, 2'd3, 2'd3);
        check_lanes("R2 emph at limit, R3 swing 0", 8'h38);
        run(3'd1, 16'hFFFF, 2'd2, 2'd2);
        check_lanes("R2 emph clamp to 2, R3 ceiling 1", 8'h31);
    endtask

    task automatic t_swing_limit();
        run(3'd4, 16'h0003, 2'd2, 2'd3);
        check_lanes("R4 swing clamp to 2", 8'h06);
        run(3'd4, 16'h0003, 2'd3, 2'd3);
        check_lanes("R4 swing at 3 R7 layout", 8'h07);
        run(3'd4, 16'h0007, 2'd3, 2'd3);
        check_lanes("R3 emph1 caps swing to 2", 8'h0A);
        run(3'd4, 16'h0007, 2'd2, 2'd3);
        check_lanes("R4 capped swing meets limit", 8'h0E);
    endtask

    task automatic t_cfg();
        run(3'd4, 16'h0000, 2'd3, 2'd1);
        check(cfg_err == 1'b1, "R5 emph limit 1", cfg_err, 1);
        run(3'd4, 16'h0000, 2'd1, 2'd3);
        check(cfg_err == 1'b1, "R5 swing limit 1", cfg_err, 1);
        run(3'd4, 16'h0000, 2'd2, 2'd2);
        check(cfg_err == 1'b0, "R5 legal limits", cfg_err, 0);
        check_lanes("R7 zero request", 8'h00);
    endtask

    task automatic t_hold();
        run(3'd4, 16'h0003, 2'd2, 2'd3);
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", done, 0);
        adj_req = 16'hFFFF; src_emph_max = 2'd0; lane_cnt = 3'd1;
        @(negedge clk);
        @(negedge clk);
        check_lanes("R8 hold without start", 8'h06);
        check(cfg_err == 1'b0, "R8 cfg_err hold", cfg_err, 0);
        check(done == 1'b0, "R8 no done without start", done, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(lane_drive == 32'h0, "R9 reset after run", lane_drive, 0);
    endtask

    initial begin
        t_reset();
        t_lane_mask();
        t_emph_limit();
        t_swing_limit();
        t_cfg();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule